// File: doc/BRIEF.md
# Programmable Resolution Time Tag Counter

This block keeps a free-running 16-bit time stamp for a serial bus terminal. A 3-bit source select picks how the count advances: one of six internal resolutions derived from the 16 MHz system clock (2, 4, 8, 16, 32 or 64 µs per LSB), rising edges on an asynchronous external tick pin, or single steps strobed by software so the counter can be exercised in self-test.

The host may overwrite the count at any time. Protocol logic reports two synchronize mode commands: the form without data clears the count and the form with data loads the received word, each only when its enable is set. When a message ends, the block captures the count on a stamp output for the descriptor writer. When an increment wraps the count from all ones to zero, the block raises a one-cycle interrupt request and sets a sticky status bit, if rollover reporting is enabled.

Top module: `time_tag_unit`

## Requirements
- R1: After reset, count_o is 0, stamp_vld_o is 0, roll_irq_o is 0 and roll_sts_o is 0.
- R2: With src_sel_i = n for n in 0..5, the count advances by one every 32·2^n clock cycles, counted from the last host write or sync load.
- R3: With src_sel_i = 6, the count advances by one, three clock edges after each rising edge of ext_tick_i, which passes through a two-flop synchronizer. A held level or a falling edge does not advance the count.
- R4: With src_sel_i = 7, each cycle with sw_step_i high advances the count by one. In any other source mode, sw_step_i has no effect.
- R5: A cycle with host_wr_i high loads host_wdata_i into the count at the next edge and restarts the prescaler phase.
- R6: With sync_ld_en_i high, a sync_ld_i cycle loads sync_data_i into the count and restarts the prescaler phase. With the enable low, the strobe is ignored.
- R7: With sync_clr_en_i high, a sync_clr_i cycle clears the count. With the enable low, the strobe is ignored.
- R8: In a single cycle, the priority order is host write, then enabled sync load, then enabled sync clear, then increment.
- R9: A cycle with eom_i high places the count as it stood in that cycle on stamp_o and drives stamp_vld_o high for exactly the next cycle.
- R10: When an increment takes the count from 0xFFFF to 0x0000 and roll_en_i is high, roll_irq_o pulses for one cycle and roll_sts_o sets. With roll_en_i low, neither happens. A write or load to zero never counts as a rollover.
- R11: roll_ack_i clears roll_sts_o. A rollover in the same cycle as the acknowledge wins, and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16 MHz system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 3 | Count source: 0..5 internal resolution, 6 external tick, 7 software step |
| ext_tick_i | input | 1 | Asynchronous external tick |
| sw_step_i | input | 1 | Software step strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 16 | Host write value |
| sync_ld_i | input | 1 | Synchronize-with-data command strobe |
| sync_ld_en_i | input | 1 | Enables the sync load |
| sync_data_i | input | 16 | Data word received with the sync command |
| sync_clr_i | input | 1 | Synchronize-without-data command strobe |
| sync_clr_en_i | input | 1 | Enables the sync clear |
| eom_i | input | 1 | End-of-message strobe |
| roll_en_i | input | 1 | Enables rollover reporting |
| roll_ack_i | input | 1 | Clears the rollover status |
| count_o | output | 16 | Current count |
| stamp_o | output | 16 | Count captured at end of message |
| stamp_vld_o | output | 1 | Stamp valid, one cycle |
| roll_irq_o | output | 1 | Rollover interrupt request pulse |
| roll_sts_o | output | 1 | Sticky rollover status |

## Verification
A prescaler phase that is wrong shows on count_o as an increment that comes one or more cycles early or late. At 2 µs resolution this is visible within 32 cycles of a write, so the bench measures the exact edge at which the count steps after each restart. A synchronizer stage too many or too few moves the external increment by a cycle, and the bench checks the count at the exact third edge. Priority or wrap faults show in the count or the interrupt outputs on the cycle right after the strobes.

// File: rtl/time_tag_pkg.sv
package time_tag_pkg;
  localparam int unsigned RES_CNT = 6;
  localparam int unsigned SEL_W   = $clog2(RES_CNT + 2);

  typedef enum logic [1:0] {SRC_PRESC, SRC_EXT, SRC_SW} src_kind_e;

  function automatic src_kind_e decode_src(input logic [SEL_W-1:0] sel);
    if (sel < SEL_W'(RES_CNT))        return SRC_PRESC;
    else if (sel == SEL_W'(RES_CNT))  return SRC_EXT;
    else                              return SRC_SW;
  endfunction
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler
  import time_tag_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] res_i,
  output logic             tick_o
);
  localparam int unsigned MAX_DIV = CLK_PER_US << RES_CNT;
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] div_q, lim;

  // period = CLK_PER_US * 2^(res+1)
  always_comb begin
    lim    = DIV_W'(CLK_PER_US) << ({1'b0, res_i} + 1'b1);
    tick_o = en_i && (div_q >= lim - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      div_q <= '0;
    else if (!en_i || restart_i || tick_o) div_q <= '0;
    else                              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tt_edge_sync.sv
module tt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tt_count.sv
module tt_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ldata_i,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (wr_i)       cnt_d = wdata_i;
    else if (ld_i)  cnt_d = ldata_i;
    else if (clr_i) cnt_d = '0;
    else if (inc_i) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_o = &cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/time_tag_unit.sv
module time_tag_unit
  import time_tag_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned CLK_PER_US = 16,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic             ext_tick_i,
  input  logic             sw_step_i,
  input  logic             host_wr_i,
  input  logic [CNT_W-1:0] host_wdata_i,
  input  logic             sync_ld_i,
  input  logic             sync_ld_en_i,
  input  logic [CNT_W-1:0] sync_data_i,
  input  logic             sync_clr_i,
  input  logic             sync_clr_en_i,
  input  logic             eom_i,
  input  logic             roll_en_i,
  input  logic             roll_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] stamp_o,
  output logic             stamp_vld_o,
  output logic             roll_irq_o,
  output logic             roll_sts_o
);
  src_kind_e kind;
  logic presc_tick, ext_rise, inc, ld, clr, wrap;

  assign kind = decode_src(src_sel_i);
  assign ld   = sync_ld_i & sync_ld_en_i;
  assign clr  = sync_clr_i & sync_clr_en_i;

  tt_prescaler #(.CLK_PER_US(CLK_PER_US)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (kind == SRC_PRESC),
    .restart_i(host_wr_i | ld),
    .res_i    (src_sel_i),
    .tick_o   (presc_tick)
  );

  tt_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_tick_i),
    .rise_o (ext_rise)
  );

  always_comb begin
    unique case (kind)
      SRC_PRESC: inc = presc_tick;
      SRC_EXT:   inc = ext_rise;
      default:   inc = sw_step_i;
    endcase
  end

  tt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (host_wr_i),
    .wdata_i(host_wdata_i),
    .ld_i   (ld),
    .ldata_i(sync_data_i),
    .clr_i  (clr),
    .inc_i  (inc),
    .count_o(count_o),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_o     <= '0;
      stamp_vld_o <= 1'b0;
      roll_irq_o  <= 1'b0;
      roll_sts_o  <= 1'b0;
    end else begin
      stamp_vld_o <= eom_i;
      if (eom_i) stamp_o <= count_o;
      roll_irq_o <= wrap & roll_en_i;
      if (wrap && roll_en_i) roll_sts_o <= 1'b1;
      else if (roll_ack_i)   roll_sts_o <= 1'b0;
    end
  end
endmodule

// File: rtl/time_tag_unit_chk.sv
module time_tag_unit_chk
  import time_tag_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] src_sel_i,
  input logic             sw_step_i,
  input logic             host_wr_i,
  input logic [CNT_W-1:0] host_wdata_i,
  input logic             sync_ld_i,
  input logic             sync_ld_en_i,
  input logic [CNT_W-1:0] sync_data_i,
  input logic             sync_clr_i,
  input logic             sync_clr_en_i,
  input logic             eom_i,
  input logic             roll_en_i,
  input logic             roll_ack_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] stamp_o,
  input logic             stamp_vld_o,
  input logic             roll_irq_o,
  input logic             roll_sts_o
);
  a_r5_host_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |=> count_o == $past(host_wdata_i));

  a_r6_sync_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && sync_ld_i && sync_ld_en_i) |=> count_o == $past(sync_data_i));

  a_r8_clear_over_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && !(sync_ld_i && sync_ld_en_i) && sync_clr_i && sync_clr_en_i)
      |=> count_o == '0);

  a_r4_sw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == SEL_W'(RES_CNT + 1) && !sw_step_i && !host_wr_i && !sync_ld_i
     && !sync_clr_i) |=> $stable(count_o));

  a_r9_stamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eom_i |=> (stamp_vld_o && stamp_o == $past(count_o)));

  a_r10_irq_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_irq_o |-> (count_o == '0 && roll_sts_o));

  a_r10_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !roll_en_i |=> !roll_irq_o);

  a_r11_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roll_ack_i && !roll_en_i) |=> !roll_sts_o);
endmodule

bind time_tag_unit time_tag_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_sel_i    (src_sel_i),
  .sw_step_i    (sw_step_i),
  .host_wr_i    (host_wr_i),
  .host_wdata_i (host_wdata_i),
  .sync_ld_i    (sync_ld_i),
  .sync_ld_en_i (sync_ld_en_i),
  .sync_data_i  (sync_data_i),
  .sync_clr_i   (sync_clr_i),
  .sync_clr_en_i(sync_clr_en_i),
  .eom_i        (eom_i),
  .roll_en_i    (roll_en_i),
  .roll_ack_i   (roll_ack_i),
  .count_o      (count_o),
  .stamp_o      (stamp_o),
  .stamp_vld_o  (stamp_vld_o),
  .roll_irq_o   (roll_irq_o),
  .roll_sts_o   (roll_sts_o)
);

// File: tb/tb_time_tag_unit.sv
module tb_time_tag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_sel = 3'd7;
  logic        ext_tick = 0, sw_step = 0, host_wr = 0, sync_ld = 0, sync_ld_en = 0;
  logic        sync_clr = 0, sync_clr_en = 0, eom = 0, roll_en = 0, roll_ack = 0;
  logic [15:0] host_wdata = '0, sync_data = '0;
  logic [15:0] count, stamp;
  logic        stamp_vld, roll_irq, roll_sts;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  time_tag_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel), .ext_tick_i(ext_tick),
    .sw_step_i(sw_step), .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .sync_ld_i(sync_ld), .sync_ld_en_i(sync_ld_en), .sync_data_i(sync_data),
    .sync_clr_i(sync_clr), .sync_clr_en_i(sync_clr_en), .eom_i(eom),
    .roll_en_i(roll_en), .roll_ack_i(roll_ack), .count_o(count), .stamp_o(stamp),
    .stamp_vld_o(stamp_vld), .roll_irq_o(roll_irq), .roll_sts_o(roll_sts)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] v);
    host_wr = 1; host_wdata = v; cyc(1); host_wr = 0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin sw_step = 1; cyc(1); end
    sw_step = 0;
  endtask

  task automatic t_reset();
    check("R1 count", count, 16'h0);
    check("R1 stamp_vld", {15'd0, stamp_vld}, 16'd0);
    check("R1 irq", {15'd0, roll_irq}, 16'd0);
    check("R1 sts", {15'd0, roll_sts}, 16'd0);
  endtask

  task automatic t_resolution(input logic [2:0] sel);
    int per;
    per = 32 << sel;
    src_sel = sel;
    wr(16'h0);
    cyc(per - 1);
    check($sformatf("R2 sel%0d before", sel), count, 16'h0);
    cyc(1);
    check($sformatf("R2 sel%0d tick", sel), count, 16'h1);
    cyc(per);
    check($sformatf("R2 sel%0d second", sel), count, 16'h2);
  endtask

  task automatic t_restart();
    src_sel = 3'd0;
    wr(16'h10);
    cyc(20);
    wr(16'h20);       // R5: phase restarts here
    cyc(31);
    check("R5 no early tick", count, 16'h20);
    cyc(1);
    check("R5 tick after restart", count, 16'h21);
    sync_ld_en = 1; sync_data = 16'h40;
    cyc(10);
    sync_ld = 1; cyc(1); sync_ld = 0;
    cyc(31);
    check("R6 load restarts phase", count, 16'h40);
    cyc(1);
    check("R6 tick after load", count, 16'h41);
    sync_ld_en = 0;
  endtask

  task automatic t_external();
    src_sel = 3'd6;
    wr(16'h5);
    ext_tick = 1;
    cyc(2);
    check("R3 not before third edge", count, 16'h5);
    cyc(1);
    check("R3 rising edge", count, 16'h6);
    cyc(6);
    check("R3 level held", count, 16'h6);
    ext_tick = 0;
    cyc(6);
    check("R3 falling edge", count, 16'h6);
    ext_tick = 1; cyc(1); ext_tick = 0; cyc(5);
    check("R3 second edge", count, 16'h7);
    step(3);
    check("R4 step ignored outside sw", count, 16'h7);
  endtask

  task automatic t_software();
    src_sel = 3'd7;
    wr(16'h100);
    step(3);
    check("R4 three steps", count, 16'h103);
    cyc(50);
    check("R4 idle hold", count, 16'h103);
  endtask

  task automatic t_sync();
    src_sel = 3'd7;
    wr(16'h1234);
    sync_data = 16'hBEEF;
    sync_ld = 1; cyc(1); sync_ld = 0;
    check("R6 load disabled", count, 16'h1234);
    sync_ld_en = 1; sync_ld = 1; cyc(1); sync_ld = 0;
    check("R6 load enabled", count, 16'hBEEF);
    sync_clr = 1; cyc(1); sync_clr = 0;
    check("R7 clear disabled", count, 16'hBEEF);
    sync_clr_en = 1; sync_clr = 1; cyc(1); sync_clr = 0;
    check("R7 clear enabled", count, 16'h0);
  endtask

  task automatic t_priority();
    src_sel = 3'd7;
    sync_ld_en = 1; sync_clr_en = 1; sync_data = 16'h5555;
    host_wr = 1; host_wdata = 16'hAAAA; sync_ld = 1; sync_clr = 1; sw_step = 1;
    cyc(1);
    check("R8 write wins", count, 16'hAAAA);
    host_wr = 0;
    cyc(1);
    check("R8 load over clear", count, 16'h5555);
    sync_ld = 0;
    cyc(1);
    check("R8 clear over step", count, 16'h0);
    sync_clr = 0; sw_step = 0;
    sync_ld_en = 0; sync_clr_en = 0;
  endtask

  task automatic t_stamp();
    src_sel = 3'd7;
    wr(16'h0ABC);
    eom = 1; sw_step = 1; cyc(1); eom = 0; sw_step = 0;
    check("R9 stamp value", stamp, 16'h0ABC);
    check("R9 stamp valid", {15'd0, stamp_vld}, 16'd1);
    cyc(1);
    check("R9 valid one cycle", {15'd0, stamp_vld}, 16'd0);
  endtask

  task automatic t_rollover();
    src_sel = 3'd7;
    roll_en = 0;
    wr(16'hFFFF);
    step(1);
    check("R10 wrap disabled count", count, 16'h0);
    check("R10 disabled no irq", {15'd0, roll_irq}, 16'd0);
    check("R10 disabled no sts", {15'd0, roll_sts}, 16'd0);
    roll_en = 1;
    wr(16'h0);
    check("R10 write zero no irq", {15'd0, roll_irq}, 16'd0);
    wr(16'hFFFF);
    step(1);
    check("R10 irq pulse", {15'd0, roll_irq}, 16'd1);
    check("R10 sts set", {15'd0, roll_sts}, 16'd1);
    cyc(1);
    check("R10 irq one cycle", {15'd0, roll_irq}, 16'd0);
    roll_ack = 1; cyc(1); roll_ack = 0;
    check("R11 ack clears", {15'd0, roll_sts}, 16'd0);
    wr(16'hFFFF);
    roll_ack = 1; sw_step = 1; cyc(1); roll_ack = 0; sw_step = 0;
    check("R11 set beats ack", {15'd0, roll_sts}, 16'd1);
    roll_en = 0;
    roll_ack = 1; cyc(1); roll_ack = 0;
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(2);
    t_reset();
    t_software();
    t_resolution(3'd0);
    t_resolution(3'd2);
    t_resolution(3'd5);
    t_restart();
    t_external();
    t_sync();
    t_priority();
    t_stamp();
    t_rollover();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(10 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule